// File: doc/BRIEF.md
# Clock Reference Quality Monitor

This block judges whether one candidate timing reference is fit to discipline a system clock. It runs entirely in a trusted local clock domain. The candidate waveform is brought in through a synchronizer, and its rising transitions are counted over a gate window of a programmable number of local cycles. The monitor watches two things separately. The first is activity: whether the candidate is still toggling at all. The second is frequency offset: whether the count for a finished window lies within an accuracy band around a programmed nominal count. The band is chosen from three tolerance classes, 4.6 ppm, 20 ppm and 32 ppm.

Either fault makes the reference unusable. The `qualified` output drops as soon as a fault is raised. It returns only after a run of consecutive good windows. Each fault also has its own flag output, so selection logic can see why a reference was rejected. One instance is placed per candidate reference. A framed external timing input is handled the same way, as a bare frequency source.

Top module: `refmon_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `qualified`, `loss_flag` and `freq_flag` all become 0.
- R2: Rising transitions of `cand_clk` are counted over consecutive windows of exactly `gate_len` local cycles (with `gate_len` at least 2). The candidate may run at no more than half the local clock rate.
- R3: `loss_flag` rises once `timeout_cycles` consecutive local cycles have passed with no detected candidate edge.
- R4: `loss_flag` falls only at the end of a gate window in which at least one edge was detected and no timeout occurred.
- R5: One cycle after each window ends, `freq_flag` is set to 1 if |count − `nominal`| exceeds the selected tolerance and to 0 otherwise. It keeps that value until the next window's verdict.
- R6: The tolerance in counts is ceil(`nominal` × ppm / 1e6). `tol_sel` 0 selects 4.6 ppm, 1 selects 20 ppm, and 2 or 3 selects 32 ppm. A difference equal to the tolerance counts as in tolerance.
- R7: `qualified` rises after the number of consecutive in-tolerance window verdicts given by `qual_need`, all taken without a loss of activity. A `qual_need` of 0 means 3.
- R8: `qualified` is 0 in every cycle in which `loss_flag` or `freq_flag` is 1. Any loss of activity restarts the run of good windows from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trusted local reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_clk | input | 1 | Candidate reference waveform, asynchronous |
| gate_len | input | GATE_W | Gate window length in local cycles |
| nominal | input | GATE_W | Expected candidate edge count per window |
| timeout_cycles | input | TO_W | Edgeless local cycles that declare loss of activity |
| tol_sel | input | 2 | Tolerance class select |
| qual_need | input | RUN_W | Good windows needed to qualify (0 selects 3) |
| qualified | output | 1 | Reference usable |
| loss_flag | output | 1 | Loss of activity fault |
| freq_flag | output | 1 | Frequency out of tolerance fault |

## Verification
The bench targets the exact tolerance boundary. At a difference equal to the rounded-up tolerance the reference must be accepted, and one count more must be rejected. A design that rounded down or compared strictly would fail one side of that boundary. The bench also stops the candidate in the middle of a run. A design that cleared the loss flag at the first new edge, or failed to restart the good-window run, would then re-qualify too early. Finally, the bench checks one window count against the 32 ppm and 20 ppm classes at a nominal large enough to separate them, which catches a swapped or mis-scaled class, as well as the default of three windows when `qual_need` is 0.

// File: rtl/refmon_pkg.sv
// Shared constants and helpers for the clock reference quality monitor.
// Assumes tolerance classes are expressed in tenths of a ppm.
package refmon_pkg;

    localparam int NUM_CLASSES = 3;
    localparam int DEFAULT_NEED = 3;

    // Class index to accuracy in tenths of ppm.
    function automatic int unsigned class_tenths(input int idx);
        case (idx)
            0:       return 46;
            1:       return 200;
            default: return 320;
        endcase
    endfunction

    // Tolerance in counts: ceil(nom * tenths / 1e7).
    function automatic logic [63:0] tol_counts(input logic [63:0] nom,
                                               input logic [63:0] tenths);
        return (nom * tenths + 64'd9999999) / 64'd10000000;
    endfunction

endpackage

// File: rtl/refmon_edge_sync.sv
// Brings an asynchronous candidate waveform into the local domain and
// produces a one-cycle pulse per rising transition.
// Assumes the candidate is no faster than half the local clock.
module refmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cand,
    output logic edge_o
);
    logic [STAGES:0] sh_q;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], cand};
    end

    // Rising transition seen at the synchronizer output.
    assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R2: a detected edge never lasts two cycles in a row.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/refmon_gate.sv
// Counts candidate edges across gate windows of gate_len local cycles and
// presents the final count with a one-cycle valid strobe.
// Assumes gate_len is at least 2.
module refmon_gate #(
    parameter int GATE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic [GATE_W-1:0] gate_len,
    output logic              roll_o,
    output logic              win_valid_o,
    output logic [GATE_W-1:0] win_count_o
);
    logic [GATE_W-1:0] gate_cnt_q;
    logic [GATE_W-1:0] edge_cnt_q;
    logic [GATE_W:0]   gate_plus;

    // Last cycle of the current window.
    assign gate_plus = {1'b0, gate_cnt_q} + (GATE_W+1)'(1);
    assign roll_o    = gate_plus >= {1'b0, gate_len};

    // Window timer and edge accumulator; latch the total at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_cnt_q  <= '0;
            edge_cnt_q  <= '0;
            win_count_o <= '0;
            win_valid_o <= 1'b0;
        end else begin
            win_valid_o <= roll_o;
            if (roll_o) begin
                gate_cnt_q  <= '0;
                edge_cnt_q  <= '0;
                win_count_o <= edge_cnt_q + GATE_W'(edge_i);
            end else begin
                gate_cnt_q  <= gate_cnt_q + 1'b1;
                edge_cnt_q  <= edge_cnt_q + GATE_W'(edge_i);
            end
        end
    end

    // R2: window verdicts are isolated strobes for windows of two or more cycles.
    a_r2_window_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && gate_len > GATE_W'(1)) |=> !win_valid_o);

endmodule

// File: rtl/refmon_activity.sv
// Declares loss of activity after timeout edgeless cycles and clears it at
// the end of a window that had edges and no timeout.
// Assumes timeout_cycles is at least 1.
module refmon_activity #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_i,
    input  logic            roll_i,
    input  logic [TO_W-1:0] timeout_cycles,
    output logic            lost_o
);
    logic [TO_W-1:0] idle_q;
    logic [TO_W:0]   idle_plus;
    logic            expire;
    logic            seen_q, expired_q;

    // Timeout fires when this edgeless cycle completes the allowed run.
    assign idle_plus = {1'b0, idle_q} + (TO_W+1)'(1);
    assign expire    = !edge_i && (idle_plus >= {1'b0, timeout_cycles});

    // Edgeless cycle counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              idle_q <= '0;
        else if (edge_i)         idle_q <= '0;
        else if (idle_q != '1)   idle_q <= idle_q + 1'b1;
    end

    // Per-window record of edges and timeouts.
    always_ff @(posedge clk) begin
        if (!rst_n || roll_i) begin
            seen_q    <= 1'b0;
            expired_q <= 1'b0;
        end else begin
            seen_q    <= seen_q | edge_i;
            expired_q <= expired_q | expire;
        end
    end

    // Loss flag: set on timeout, cleared by a clean active window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost_o <= 1'b0;
        else if (expire)
            lost_o <= 1'b1;
        else if (roll_i && (seen_q || edge_i) && !expired_q)
            lost_o <= 1'b0;
    end

    // R4: recovery only happens at a window boundary.
    a_r4_clear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost_o) |-> $past(roll_i));

    // R3: a detected edge never coincides with a new loss declaration.
    a_r3_edge_blocks_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !lost_o) |=> !lost_o);

endmodule

// File: rtl/refmon_top.sv
// Clock reference quality monitor: combines activity and frequency-offset
// checks into a qualified status with separate fault flags.
// Assumes nominal and gate_len are held steady across the windows of interest.
module refmon_top #(
    parameter int GATE_W = 20,
    parameter int TO_W   = 16,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_clk,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [GATE_W-1:0] nominal,
    input  logic [TO_W-1:0]   timeout_cycles,
    input  logic [1:0]        tol_sel,
    input  logic [RUN_W-1:0]  qual_need,
    output logic              qualified,
    output logic              loss_flag,
    output logic              freq_flag
);
    import refmon_pkg::*;

    localparam int NCLS = NUM_CLASSES;

    logic              edge_w, roll_w, win_valid_w;
    logic [GATE_W-1:0] win_count_w;
    logic [GATE_W-1:0] tol_q [NCLS];
    logic [1:0]        cls;
    logic [GATE_W-1:0] diff, tol_sel_v;
    logic              in_tol;
    logic [RUN_W-1:0]  run_q, need_eff;
    logic              freq_q;

    refmon_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .cand(cand_clk), .edge_o(edge_w));

    refmon_gate #(.GATE_W(GATE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .gate_len(gate_len),
        .roll_o(roll_w), .win_valid_o(win_valid_w), .win_count_o(win_count_w));

    refmon_activity #(.TO_W(TO_W)) u_act (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .roll_i(roll_w),
        .timeout_cycles(timeout_cycles), .lost_o(loss_flag));

    // Per-class tolerance in counts, recomputed from the nominal count.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NCLS; c++) begin
            if (!rst_n) tol_q[c] <= '0;
            else        tol_q[c] <= GATE_W'(tol_counts(64'(nominal), 64'(class_tenths(c))));
        end
    end

    // Class select, with code 3 folded onto the widest class.
    assign cls       = (tol_sel > 2'd2) ? 2'd2 : tol_sel;
    assign tol_sel_v = tol_q[cls];

    // Absolute offset of the finished window from nominal.
    assign diff   = (win_count_w >= nominal) ? win_count_w - nominal : nominal - win_count_w;
    assign in_tol = diff <= tol_sel_v;

    // Required run length, with 0 meaning the default.
    assign need_eff = (qual_need == '0) ? RUN_W'(DEFAULT_NEED) : qual_need;

    // Frequency verdict, refreshed once per window.
    always_ff @(posedge clk) begin
        if (!rst_n)           freq_q <= 1'b0;
        else if (win_valid_w) freq_q <= !in_tol;
    end

    // Run of consecutive good windows; restarted by any fault.
    always_ff @(posedge clk) begin
        if (!rst_n || loss_flag)
            run_q <= '0;
        else if (win_valid_w)
            run_q <= !in_tol ? '0 : (run_q == '1) ? run_q : run_q + 1'b1;
    end

    assign freq_flag = freq_q;
    assign qualified = !loss_flag && !freq_q && (run_q >= need_eff);

    // R5: the frequency flag only moves right after a window verdict.
    a_r5_verdict_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_flag != $past(freq_flag)) |-> $past(win_valid_w));

    // R7: qualification is only gained right after a window verdict.
    a_r7_rise_after_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(win_valid_w));

    // R8: a new loss of activity removes qualification in the same cycle.
    a_r8_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_flag) |-> !qualified);

endmodule

// File: tb/sim_refmon_top.sv
// Bench: behavioural per-cycle model compared on every clock plus scenario checks.
module sim_refmon_top;
    localparam int CLK_PERIOD = 10;
    localparam int GATE_W = 20, TO_W = 16, RUN_W = 4;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cand = 1'b0;
    logic [GATE_W-1:0] gate_len = 20'd200;
    logic [GATE_W-1:0] nominal = 20'd100;
    logic [TO_W-1:0]   timeout_cycles = 16'd20;
    logic [1:0]        tol_sel = 2'd0;
    logic [RUN_W-1:0]  qual_need = 4'd0;
    logic qualified, loss_flag, freq_flag;

    int checks = 0, fails = 0, cycles = 0;
    int half = 0, ph = 0;
    bit started = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refmon_top #(.GATE_W(GATE_W), .TO_W(TO_W), .RUN_W(RUN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cand_clk(cand), .gate_len(gate_len),
        .nominal(nominal), .timeout_cycles(timeout_cycles), .tol_sel(tol_sel),
        .qual_need(qual_need), .qualified(qualified), .loss_flag(loss_flag),
        .freq_flag(freq_flag));

    // Candidate stimulus: toggles every `half` local cycles, frozen when 0.
    always @(negedge clk) begin
        if (half > 0) begin
            ph = ph + 1;
            if (ph >= half) begin cand = ~cand; ph = 0; end
        end
    end

    // Reference model state.
    bit     hist[$] = '{0, 0, 0};
    longint m_idle, m_gcnt, m_ecnt, m_wc, m_run;
    bit     m_wv, m_lost, m_ff, m_seen, m_exp;
    longint m_tol[3];

    function automatic longint tenths(int c);
        return (c == 0) ? 46 : (c == 1) ? 200 : 320;
    endfunction

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_idle = 0; m_gcnt = 0; m_ecnt = 0; m_wc = 0; m_run = 0;
            m_wv = 0; m_lost = 0; m_ff = 0; m_seen = 0; m_exp = 0;
            foreach (m_tol[i]) m_tol[i] = 0;
        end else begin
            bit e, expire, roll, intol;
            longint d;
            int c;
            e = hist[1] && !hist[2];
            expire = !e && (m_idle + 1 >= longint'(timeout_cycles));
            roll = (m_gcnt + 1 >= longint'(gate_len));
            c = (tol_sel > 2) ? 2 : int'(tol_sel);
            d = m_wc - longint'(nominal);
            if (d < 0) d = -d;
            intol = d <= m_tol[c];
            if (m_lost) m_run = 0;
            else if (m_wv) m_run = intol ? ((m_run < 15) ? m_run + 1 : 15) : 0;
            if (m_wv) m_ff = !intol;
            if (expire) m_lost = 1;
            else if (roll && (m_seen || e) && !m_exp) m_lost = 0;
            if (roll) begin m_seen = 0; m_exp = 0; end
            else begin m_seen = m_seen | e; m_exp = m_exp | expire; end
            if (e) m_idle = 0; else if (m_idle < 65535) m_idle = m_idle + 1;
            if (roll) begin m_wc = m_ecnt + e; m_ecnt = 0; m_gcnt = 0; end
            else begin m_ecnt = m_ecnt + e; m_gcnt = m_gcnt + 1; end
            m_wv = roll;
            for (int k = 0; k < 3; k++)
                m_tol[k] = (longint'(nominal) * tenths(k) + 9999999) / 10000000;
            hist.push_front(cand);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s got %0b expected %0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            longint need;
            need = (qual_need == 0) ? 3 : longint'(qual_need);
            chk("R7/R8 qualified", qualified, !m_lost && !m_ff && (m_run >= need));
            chk("R3/R4 loss_flag", loss_flag, m_lost);
            chk("R5/R6 freq_flag", freq_flag, m_ff);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements) got %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        wait_cyc(3);
        chk("R1 qualified in reset", qualified, 1'b0);
        chk("R1 loss_flag in reset", loss_flag, 1'b0);
        chk("R1 freq_flag in reset", freq_flag, 1'b0);
        rst_n = 1'b1;
        half = 1;
        // R2, R7: steady candidate at nominal count, default run of three.
        wait_cyc(6*200 + 10);
        chk("R2 freq_flag on exact count", freq_flag, 1'b0);
        chk("R7 qualified after default run", qualified, 1'b1);
        // R3, R8: candidate stops.
        half = 0;
        wait_cyc(30);
        chk("R3 loss_flag after timeout", loss_flag, 1'b1);
        chk("R8 qualified dropped on loss", qualified, 1'b0);
        chk("R3 freq_flag independent of loss", freq_flag, 1'b0);
        // R4: resume; loss clears after a clean window.
        half = 1;
        wait_cyc(2*200 + 10);
        chk("R4 loss_flag cleared after clean window", loss_flag, 1'b0);
        wait_cyc(4*200);
        chk("R7 requalified after run", qualified, 1'b1);
        // R5: half rate candidate gives 50 counts against 100.
        half = 2;
        wait_cyc(3*200);
        chk("R5 freq_flag on 50 vs 100", freq_flag, 1'b1);
        chk("R8 qualified dropped on freq fault", qualified, 1'b0);
        chk("R5 loss_flag stays low", loss_flag, 1'b0);
        // R6: boundary at 4.6 ppm, tolerance 1 count.
        half = 1;
        nominal = 20'd101;
        wait_cyc(3*200);
        chk("R6 difference equal to tolerance accepted", freq_flag, 1'b0);
        nominal = 20'd102;
        wait_cyc(2*200 + 10);
        chk("R6 difference above tolerance rejected", freq_flag, 1'b1);
        // R6: classes separated at nominal 32000 (32 ppm -> 2, 20 ppm -> 1).
        rst_n = 1'b0;
        half = 0;
        gate_len = 20'd64004;
        nominal = 20'd32000;
        tol_sel = 2'd2;
        qual_need = 4'd1;
        wait_cyc(3);
        rst_n = 1'b1;
        half = 1;
        wait_cyc(64004 + 10);
        chk("R6 32 ppm class accepts offset 2", freq_flag, 1'b0);
        chk("R7 single window run qualifies", qualified, 1'b1);
        tol_sel = 2'd1;
        wait_cyc(64004);
        chk("R6 20 ppm class rejects offset 2", freq_flag, 1'b1);
        chk("R8 qualified low after reject", qualified, 1'b0);
        finish_run();
    end
endmodule